// File: doc/BRIEF.md
# Programmable-Delay Gray-Pointer Byte FIFO

This block is a circular byte buffer whose write and read pointers walk the reflected Gray-code sequence, so that consecutive addresses differ in one bit. After reinitialisation the write pointer sits at code zero and the read pointer sits at a code taken from a host-written delay register. The read pointer therefore leads the write pointer by the sequence index of that code. When both strobes are applied in the same cycles, a byte written now comes out of the read port after the remaining distance around the ring.

The host programs the delay code and a control word through a small register port. Only delay codes with an even number of one bits are taken. Any write to the delay register restarts both pointers. A collision is a write landing on the address the read pointer holds, or a read taken from the address the write pointer holds. A collision sets a sticky flag. With the auto-restart option enabled, a collision also restarts both pointers and drops the access that caused it.

Top module: `gdly_fifo`

## Requirements
- R1: After reset, `collision` and `delay_err` are 0, `rd_data` is 0, the delay code is `RESET_DELAY` (0x60 by default), the write pointer is at code 0 and the read pointer is at `RESET_DELAY`.
- R2: Each accepted strobe moves its pointer one step along the reflected Gray sequence (code of index i is i XOR (i>>1)), wrapping after 2**AW positions. Under paired strobes the read pointer stays ahead by the index of the delay code, so with code 0x60 (index 64) the byte written at paired step k is read at step k+64.
- R3: A host write to the delay register (`host_sel`=0) restarts the pointers (write to code 0, read to the held delay code) and clears `collision`. Strobes in that same cycle are ignored.
- R4: A delay write whose value has an odd number of one bits is rejected: the previous delay code is kept, and `delay_err` is set and stays set. An even-parity value is stored.
- R5: A write strobe while the write pointer equals the read pointer sets `collision` (overrun). Starting from a restart with a delay code of index L, L writes alone do not set it and write L+1 does.
- R6: A read strobe while the read pointer equals the write pointer sets `collision` (underrun). With delay code 0x41 (index 126), two reads alone pass and the third read collides.
- R7: With auto-restart off, `collision` stays set while the pointers keep moving, until a control write (`host_sel`=1) with bit 1 set or a delay write clears it.
- R8: With control bit 0 set (auto-restart), a collision also restarts both pointers, and the colliding write or read is discarded: no RAM write and no `rd_data` update.
- R9: `rd_data` shows the RAM content at the read pointer on the clock edge of an accepted read strobe, and holds its value in cycles without one.
- R10: A control write with bit 2 set clears `delay_err`.
- R11: Delay code 0x41 gives the largest lead the parity rule allows (126 positions). Code 0x60 gives a lead of 64, half the ring, which is the centre between overrun and underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Byte to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered read byte |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the delay register, 1 selects the control word |
| host_wdata | input | AW | Host write value (control: bit0 auto-restart, bit1 clear collision, bit2 clear parity error) |
| collision | output | 1 | Sticky collision flag |
| delay_err | output | 1 | Sticky rejected-delay flag |

## Verification
The bench builds the block with its defaults: AW=7 (a 128-position ring), DW=8 and RESET_DELAY=0x60. These values make the documented codes meaningful. Code 0x41 sits at index 126 and 0x40, the last code in the sequence, has odd parity. Paired-strobe data checks of the 64-step lead therefore reach the ring's wrap point, and overrun runs with the maximum lead of 126 stay well within the cycle budget.

// File: rtl/gdly_pkg.sv
package gdly_pkg;
   typedef enum logic {
      SEL_DELAY = 1'b0,
      SEL_CTRL  = 1'b1
   } host_sel_e;

   localparam int CTRL_AUTO_BIT    = 0;
   localparam int CTRL_CLR_COL_BIT = 1;
   localparam int CTRL_CLR_ERR_BIT = 2;

   // Gray to binary: bit i is the XOR of all Gray bits at or above i
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
      return b;
   endfunction
endpackage

// File: rtl/gdly_gray_ptr.sv
module gdly_gray_ptr #(
   parameter int AW = 7,
   parameter logic [AW-1:0] RST_GRAY = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_gray,
   input  logic          step,
   output logic [AW-1:0] gray
);
   localparam logic [AW-1:0] RST_BIN = AW'(gdly_pkg::gray_to_bin(32'(RST_GRAY)));

   logic [AW-1:0] bin_q;
   logic [AW-1:0] load_bin;

   for (genvar i = 0; i < AW; i++) begin : g_g2b
      assign load_bin[i] = ^(load_gray >> i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bin_q <= RST_BIN;
      else if (load) bin_q <= load_bin;
      else if (step) bin_q <= bin_q + 1'b1;
   end

   assign gray = bin_q ^ (bin_q >> 1);
endmodule

// File: rtl/gdly_host_regs.sv
module gdly_host_regs #(
   parameter int AW = 7,
   parameter logic [AW-1:0] RESET_DELAY = 'h60
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_sel,
   input  logic [AW-1:0] host_wdata,
   input  logic          coll_evt,
   output logic          delay_wr,
   output logic [AW-1:0] load_code,
   output logic [AW-1:0] delay_q,
   output logic          auto_en,
   output logic          collision,
   output logic          delay_err
);
   import gdly_pkg::*;

   logic ctrl_wr, odd;

   assign delay_wr  = host_we && (host_sel == SEL_DELAY);
   assign ctrl_wr   = host_we && (host_sel == SEL_CTRL);
   assign odd       = ^host_wdata;
   assign load_code = (delay_wr && !odd) ? host_wdata : delay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_q   <= RESET_DELAY;
         auto_en   <= 1'b0;
         collision <= 1'b0;
         delay_err <= 1'b0;
      end else begin
         if (delay_wr && !odd) delay_q <= host_wdata;
         if (ctrl_wr) auto_en <= host_wdata[CTRL_AUTO_BIT];
         if (delay_wr && odd)                             delay_err <= 1'b1;
         else if (ctrl_wr && host_wdata[CTRL_CLR_ERR_BIT]) delay_err <= 1'b0;
         if (delay_wr)                                     collision <= 1'b0;
         else if (ctrl_wr && host_wdata[CTRL_CLR_COL_BIT]) collision <= 1'b0;
         else if (coll_evt)                                collision <= 1'b1;
      end
   end
endmodule

// File: rtl/gdly_collide.sv
module gdly_collide #(
   parameter int AW = 7
)(
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] wr_ptr,
   input  logic [AW-1:0] rd_ptr,
   output logic          overrun,
   output logic          underrun
);
   logic same;
   assign same     = (wr_ptr == rd_ptr);
   assign overrun  = wr_en && same;
   assign underrun = rd_en && same;
endmodule

// File: rtl/gdly_ram.sv
module gdly_ram #(
   parameter int AW = 7,
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/gdly_fifo.sv
module gdly_fifo #(
   parameter int AW = 7,
   parameter int DW = 8,
   parameter logic [AW-1:0] RESET_DELAY = 'h60
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   input  logic          host_we,
   input  logic          host_sel,
   input  logic [AW-1:0] host_wdata,
   output logic          collision,
   output logic          delay_err
);
   if (AW < 3) begin : g_bad_aw
      $error("gdly_fifo: AW must be at least 3 to hold the control bits");
   end
   if (DW < 1) begin : g_bad_dw
      $error("gdly_fifo: DW must be positive");
   end
   if (^RESET_DELAY) begin : g_bad_delay
      $error("gdly_fifo: RESET_DELAY must have even parity");
   end

   logic [AW-1:0] wr_gray, rd_gray, delay_q, load_code;
   logic          delay_wr, auto_en, overrun, underrun;
   logic          coll_evt, reinit, wr_go, rd_go;

   gdly_host_regs #(.AW(AW), .RESET_DELAY(RESET_DELAY)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .coll_evt(coll_evt), .delay_wr(delay_wr),
      .load_code(load_code), .delay_q(delay_q), .auto_en(auto_en),
      .collision(collision), .delay_err(delay_err)
   );

   gdly_collide #(.AW(AW)) u_coll (
      .wr_en(wr_en), .rd_en(rd_en), .wr_ptr(wr_gray), .rd_ptr(rd_gray),
      .overrun(overrun), .underrun(underrun)
   );

   assign coll_evt = (overrun || underrun) && !delay_wr;
   assign reinit   = delay_wr || (auto_en && coll_evt);
   assign wr_go    = wr_en && !reinit;
   assign rd_go    = rd_en && !reinit;

   gdly_gray_ptr #(.AW(AW), .RST_GRAY('0)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(reinit), .load_gray('0),
      .step(wr_go), .gray(wr_gray)
   );

   gdly_gray_ptr #(.AW(AW), .RST_GRAY(RESET_DELAY)) u_rptr (
      .clk(clk), .rst_n(rst_n), .load(reinit), .load_gray(load_code),
      .step(rd_go), .gray(rd_gray)
   );

   gdly_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_go), .waddr(wr_gray), .wdata(wr_data),
      .re(rd_go), .raddr(rd_gray), .rdata(rd_data)
   );
endmodule

// File: rtl/gdly_fifo_chk.sv
module gdly_fifo_chk #(
   parameter int AW = 7
)(
   input logic          clk,
   input logic          rst_n,
   input logic          host_we,
   input logic          host_sel,
   input logic [AW-1:0] host_wdata,
   input logic          auto_en,
   input logic          coll_evt,
   input logic [AW-1:0] wr_ptr,
   input logic [AW-1:0] rd_ptr,
   input logic [AW-1:0] delay_q,
   input logic          collision,
   input logic          delay_err
);
   // R2: outside restarts, each pointer changes by at most one bit per cycle
   a_r2_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_we && !host_sel) && !(auto_en && coll_evt)) |=>
      ($countones(wr_ptr ^ $past(wr_ptr)) <= 1 && $countones(rd_ptr ^ $past(rd_ptr)) <= 1));

   // R3: a delay-register write restarts both pointers
   a_r3_host_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !host_sel) |=> (wr_ptr == '0 && rd_ptr == delay_q && !collision));

   // R4: odd-parity delay write is refused and flagged
   a_r4_odd_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !host_sel && ^host_wdata) |=> (delay_q == $past(delay_q) && delay_err));

   // R4: the held delay code always has even parity
   a_r4_even_held: assert property (@(posedge clk) disable iff (!rst_n)
      (^delay_q) == 1'b0);

   // R7: collision flag is sticky without host action
   a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (collision && !host_we) |=> collision);

   // R8: auto-restart after a collision
   a_r8_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && coll_evt) |=> (wr_ptr == '0 && rd_ptr == delay_q && collision));
endmodule

bind gdly_fifo gdly_fifo_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
   .host_wdata(host_wdata), .auto_en(auto_en), .coll_evt(coll_evt),
   .wr_ptr(wr_gray), .rd_ptr(rd_gray), .delay_q(delay_q),
   .collision(collision), .delay_err(delay_err)
);

// File: tb/gdly_fifo_test.sv
module gdly_fifo_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 7;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          host_we = 1'b0;
   logic          host_sel = 1'b0;
   logic [AW-1:0] host_wdata = '0;
   logic          collision, delay_err;

   int checks = 0;
   int errors = 0;

   gdly_fifo #(.AW(AW), .DW(DW), .RESET_DELAY(7'h60)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .host_we(host_we),
      .host_sel(host_sel), .host_wdata(host_wdata),
      .collision(collision), .delay_err(delay_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // {accepted, delay code, expected lead}
   localparam logic [15:0] VEC [6] = '{
      {1'b1, 7'h60, 8'd64},
      {1'b1, 7'h41, 8'd126},
      {1'b0, 7'h40, 8'd126},
      {1'b1, 7'h03, 8'd2},
      {1'b0, 7'h07, 8'd2},
      {1'b1, 7'h0C, 8'd8}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: drive at a falling edge, return at the next falling edge
   task automatic cyc(input bit we, input int wd, input bit re);
      wr_en = we; wr_data = DW'(wd); rd_en = re;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic hw(input bit sel, input int val);
      host_we = 1'b1; host_sel = sel; host_wdata = AW'(val);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(collision == 1'b0, "R1 collision", collision, 0);
      chk(delay_err == 1'b0, "R1 delay_err", delay_err, 0);
      chk(rd_data == '0, "R1 rd_data", rd_data, 0);

      // R2 R9 R1: paired strobes with reset delay 0x60, lead 64
      for (int k = 0; k < 100; k++) begin
         cyc(1'b1, k, 1'b1);
         if (k >= 64 && (k % 6 == 0))
            chk(rd_data == DW'(k - 64), "R2 delayed byte", rd_data, k - 64);
      end
      chk(collision == 1'b0, "R5 no false collision", collision, 0);
      held = rd_data;
      cyc(1'b0, 8'h55, 1'b0);
      chk(rd_data == held, "R9 rd_data holds", rd_data, held);

      // R4 R5 R10 R11: table of delay codes
      for (int v = 0; v < 6; v++) begin
         hw(1'b0, int'(VEC[v][14:8]));
         chk(delay_err == !VEC[v][15], "R4 parity accept", delay_err, !VEC[v][15]);
         chk(collision == 1'b0, "R3 collision cleared", collision, 0);
         hw(1'b1, 3'b100);
         chk(delay_err == 1'b0, "R10 error cleared", delay_err, 0);
         for (int j = 0; j < int'(VEC[v][7:0]); j++) cyc(1'b1, j, 1'b0);
         chk(collision == 1'b0, "R5 R11 lead writes", collision, 0);
         cyc(1'b1, 0, 1'b0);
         chk(collision == 1'b1, "R5 R11 overrun", collision, 1);
      end

      // R6: underrun with code 0x41
      hw(1'b0, 7'h41);
      cyc(1'b0, 0, 1'b1);
      cyc(1'b0, 0, 1'b1);
      chk(collision == 1'b0, "R6 two reads pass", collision, 0);
      cyc(1'b0, 0, 1'b1);
      chk(collision == 1'b1, "R6 underrun", collision, 1);

      // R7: sticky while running, cleared by control bit 1
      cyc(1'b1, 1, 1'b1);
      cyc(1'b1, 2, 1'b1);
      chk(collision == 1'b1, "R7 sticky", collision, 1);
      hw(1'b1, 3'b010);
      chk(collision == 1'b0, "R7 cleared", collision, 0);

      // R3: a repeat delay write restarts the pointers
      hw(1'b0, 7'h03);
      cyc(1'b1, 9, 1'b0);
      hw(1'b0, 7'h03);
      cyc(1'b1, 9, 1'b0);
      cyc(1'b1, 9, 1'b0);
      chk(collision == 1'b0, "R3 pointers restarted", collision, 0);
      cyc(1'b1, 9, 1'b0);
      chk(collision == 1'b1, "R3 overrun after restart", collision, 1);

      // R8: auto-restart discards the colliding write
      hw(1'b1, 3'b001);
      hw(1'b0, 7'h03);
      cyc(1'b1, 8'hA0, 1'b0);
      cyc(1'b1, 8'hA1, 1'b0);
      chk(collision == 1'b0, "R8 before collision", collision, 0);
      cyc(1'b1, 8'hFF, 1'b0);
      chk(collision == 1'b1, "R8 collision flagged", collision, 1);
      hw(1'b1, 3'b011);
      chk(collision == 1'b0, "R8 flag cleared", collision, 0);
      cyc(1'b1, 8'hB0, 1'b0);
      cyc(1'b1, 8'hB1, 1'b0);
      chk(collision == 1'b0, "R8 pointers restarted", collision, 0);
      cyc(1'b1, 8'hFF, 1'b0);
      chk(collision == 1'b1, "R8 second collision", collision, 1);
      cyc(1'b0, 0, 1'b1);
      chk(rd_data != 8'hFF, "R8 colliding write discarded", rd_data, 8'h09);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule